// File: doc/BRIEF.md
# Four-Phase Accumulator Computer

This block is a complete small 8-bit accumulator computer. It holds a program counter, an instruction register, an accumulator, an operand latch and a 32-word internal memory. A two-bit phase counter takes every instruction through the same four steps: two fetch phases (I1, I2) and two execute phases (E1, E2). Each step issues one set of microcommands, picked from the opcode and the phase: load the instruction register, advance or load the program counter, clear, complement, shift or load the accumulator, write memory, and choose the memory address source.

A front panel drives the machine. In manual mode the phase counter is frozen. The address switches then choose the memory word that is shown, and a write strobe stores the data switches into that word. This is how a program is entered and how results are read back. In automatic mode a start pulse sets the run flag. The machine then runs until it executes a halt instruction. A later start pulse resumes from the word that follows the halt. The two display outputs always show the current memory address and the word held at that address.

Top module: `acc4_cpu`

## Requirements
- R1: While rst_n is low, and just after it is released, phase is 0, pc is 0, acc is 0 and running is 0.
- R2: The phase encoding is I1=0, I2=1, E1=2, E2=3. The phase advances by one on each clock, wrapping from 3 to 0, only while running is 1 and man_mode is 0. In every other case it holds.
- R3: In I1 the instruction register loads the memory word at pc. In I2, pc increments by one, modulo 32.
- R4: disp_addr is sw_addr in manual mode. In automatic mode it is the instruction's low five bits during E1 of ADD or MEM, and pc at all other times. disp_data is the memory word at disp_addr.
- R5: The instruction's opcode is bits 7..5: 000 halt, 001 ADD, 010 store (MEM), 011 JMP, 100 group. In the group, bits 2..0 select 000 NOP, 001 CLA, 010 CPL, 011 SHR, 100 SHL, 101 SKIPO, 110 SKIPN and 111 NOP. Opcodes 101, 110 and 111 act as NOP. Bits 4..0 form the address field.
- R6: In E1, JMP loads pc with the address field, CLA clears acc and CPL inverts every bit of acc.
- R7: In E1, SKIPO adds one more to pc when acc bit 0 is 1, and SKIPN does so when acc bit 7 is 1. Otherwise pc is unchanged.
- R8: In E2, ADD loads acc with acc plus the addressed word, modulo 256. SHR and SHL shift acc by one place and fill the vacated bit with 0. MEM writes acc into the addressed word. acc never changes in I1 or I2.
- R9: In E2 of the halt instruction, running clears and the phase returns to I1. A start pulse in automatic mode sets running, and execution continues at pc.
- R10: While man_mode is 1, pc, acc and phase hold and start has no effect. sw_write stores sw_data into the word at sw_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low initialise |
| start | input | 1 | Sets the run flag (automatic mode only) |
| man_mode | input | 1 | 1 = front-panel manual mode, 0 = automatic |
| sw_addr | input | 5 | Address switches |
| sw_data | input | 8 | Data switches |
| sw_write | input | 1 | Manual memory write strobe |
| disp_addr | output | 5 | Current memory address |
| disp_data | output | 8 | Word at the current memory address |
| phase | output | 2 | Current phase |
| pc | output | 5 | Program counter |
| acc | output | 8 | Accumulator |
| running | output | 1 | Run flag |

## Verification
Several rules are checked by the assertions on every clock. The phase steps and holds correctly. pc advances in I2. acc stays unchanged during fetch. The halt instruction clears the run flag. The machine stays frozen in manual mode. Only the bench's program can show that each opcode computes the right result: the skips taken and not taken, the carry lost in ADD, the zero-filled shifts, the stored word read back over the panel, and the resume after a halt. The bench shows these by comparing pc, acc, phase, run flag and both displays against a behavioural model on every clock.

// File: rtl/acc4_cpu.sv
module acc4_cpu #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          man_mode,
  input  logic [AW-1:0] sw_addr,
  input  logic [DW-1:0] sw_data,
  input  logic          sw_write,
  output logic [AW-1:0] disp_addr,
  output logic [DW-1:0] disp_data,
  output logic [1:0]    phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc,
  output logic          running
);
  localparam int WORDS = 1 << AW;
  localparam logic [1:0] PH_I1 = 2'd0, PH_I2 = 2'd1, PH_E1 = 2'd2, PH_E2 = 2'd3;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] ir, mdr, rdata;
  logic [2:0]    opc, sub;
  logic [AW-1:0] field;
  logic          step, sel_id;
  logic          op_stop, op_add, op_mem, op_jmp, grp;

  assign opc     = ir[DW-1 -: 3];
  assign sub     = ir[2:0];
  assign field   = ir[AW-1:0];
  assign op_stop = opc == 3'b000;
  assign op_add  = opc == 3'b001;
  assign op_mem  = opc == 3'b010;
  assign op_jmp  = opc == 3'b011;
  assign grp     = opc == 3'b100;

  assign step      = running & ~man_mode;
  assign sel_id    = (phase == PH_E1) & (op_add | op_mem);
  assign disp_addr = man_mode ? sw_addr : (sel_id ? field : pc);
  assign rdata     = mem[disp_addr];
  assign disp_data = rdata;

  always_ff @(posedge clk) begin
    if (man_mode && sw_write)
      mem[sw_addr] <= sw_data;
    else if (step && phase == PH_E2 && op_mem)
      mem[field] <= acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_I1;
      pc      <= '0;
      acc     <= '0;
      ir      <= '0;
      mdr     <= '0;
      running <= 1'b0;
    end else begin
      if (step && phase == PH_E2 && op_stop) running <= 1'b0;
      else if (start && !man_mode)           running <= 1'b1;
      if (step) begin
        phase <= phase + 2'd1;
        case (phase)
          PH_I1: ir <= rdata;
          PH_I2: pc <= pc + 1'b1;
          PH_E1: begin
            mdr <= rdata;
            if (op_jmp) pc <= field;
            if (grp) begin
              case (sub)
                3'b001: acc <= '0;
                3'b010: acc <= ~acc;
                3'b101: if (acc[0])    pc <= pc + 1'b1;
                3'b110: if (acc[DW-1]) pc <= pc + 1'b1;
                default: ;
              endcase
            end
          end
          default: begin
            if (op_add) acc <= acc + mdr;
            if (grp && sub == 3'b011) acc <= acc >> 1;
            if (grp && sub == 3'b100) acc <= acc << 1;
          end
        endcase
      end
    end
  end
endmodule

module acc4_cpu_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          man_mode,
  input logic [1:0]    phase,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] ir,
  input logic          running
);
  logic go;
  assign go = running & ~man_mode;

  p_phase_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> phase == 2'($past(phase) + 2'd1));
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> phase == $past(phase));
  p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && phase == 2'd1) |=> pc == AW'($past(pc) + 1'b1));
  p_fetch_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !phase[1]) |=> $stable(acc));
  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && phase == 2'd3 && ir[DW-1 -: 3] == 3'b000) |=> !running);
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    man_mode |=> ($stable(pc) && $stable(acc) && $stable(phase)));
endmodule

bind acc4_cpu acc4_cpu_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .man_mode(man_mode), .phase(phase),
  .pc(pc), .acc(acc), .ir(ir), .running(running)
);

// File: tb/acc4_cpu_tb_top.sv
module acc4_cpu_tb_top;
  logic       clk = 0, rst_n = 0, start = 0, man_mode = 0, sw_write = 0;
  logic [4:0] sw_addr = 0;
  logic [7:0] sw_data = 0;
  logic [4:0] disp_addr, pc;
  logic [7:0] disp_data, acc;
  logic [1:0] phase;
  logic       running;

  int checks = 0, errors = 0, cyc = 0;
  bit loaded = 0;
  int m_ph, m_pc, m_acc, m_ir, m_mdr, m_run;
  int m_mem [32];
  int prog [32];

  always #5 clk = ~clk;

  acc4_cpu dut_i (.clk(clk), .rst_n(rst_n), .start(start), .man_mode(man_mode),
    .sw_addr(sw_addr), .sw_data(sw_data), .sw_write(sw_write),
    .disp_addr(disp_addr), .disp_data(disp_data), .phase(phase), .pc(pc),
    .acc(acc), .running(running));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_acc = 0; m_ir = 0; m_mdr = 0; m_run = 0;
    end else begin
      int op, sb, fa;
      bit go;
      op = m_ir >> 5; sb = m_ir & 7; fa = m_ir & 31;
      go = m_run && !man_mode;
      if (man_mode && sw_write) m_mem[sw_addr] = sw_data;
      else if (go && m_ph == 3 && op == 2) m_mem[fa] = m_acc;
      if (go && m_ph == 3 && op == 0) m_run = 0;
      else if (start && !man_mode) m_run = 1;
      if (go) begin
        if (m_ph == 0) m_ir = m_mem[m_pc];
        else if (m_ph == 1) m_pc = (m_pc + 1) % 32;
        else if (m_ph == 2) begin
          m_mdr = m_mem[fa];
          if (op == 3) m_pc = fa;
          if (op == 4) begin
            if (sb == 1) m_acc = 0;
            if (sb == 2) m_acc = 255 - m_acc;
            if (sb == 5 && (m_acc & 1) != 0) m_pc = (m_pc + 1) % 32;
            if (sb == 6 && (m_acc & 128) != 0) m_pc = (m_pc + 1) % 32;
          end
        end else begin
          if (op == 1) m_acc = (m_acc + m_mdr) % 256;
          if (op == 4 && sb == 3) m_acc = m_acc >> 1;
          if (op == 4 && sb == 4) m_acc = (m_acc << 1) % 256;
        end
        m_ph = (m_ph + 1) % 4;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    int ea;
    chk("R2 phase", phase, m_ph);
    chk("R3 pc", pc, m_pc);
    chk("R8 acc", acc, m_acc);
    chk("R9 running", running, m_run);
    if (man_mode) ea = sw_addr;
    else if (m_ph == 2 && ((m_ir >> 5) == 1 || (m_ir >> 5) == 2)) ea = m_ir & 31;
    else ea = m_pc;
    chk("R4 disp_addr", disp_addr, ea);
    if (loaded) chk("R10 disp_data", disp_data, m_mem[ea]);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    cmp_all();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) prog[i] = 0;
    prog[0] = 8'h81;  prog[1] = 8'h34;  prog[2] = 8'h85;  prog[3] = 8'h00;
    prog[4] = 8'h86;  prog[5] = 8'h00;  prog[6] = 8'h84;  prog[7] = 8'h86;
    prog[8] = 8'h35;  prog[9] = 8'h83;  prog[10] = 8'h82; prog[11] = 8'h56;
    prog[12] = 8'h85; prog[13] = 8'h00; prog[14] = 8'h72; prog[18] = 8'h80;
    prog[19] = 8'h00; prog[20] = 8'h81; prog[21] = 8'hFF; prog[22] = 8'h00;
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
  end

  initial begin
    int runcyc;
    repeat (3) tick();
    chk("R1 phase", phase, 0); chk("R1 pc", pc, 0);
    chk("R1 acc", acc, 0);     chk("R1 running", running, 0);
    rst_n = 1;
    tick();
    chk("R1 released running", running, 0);
    man_mode = 1;
    for (int a = 0; a < 32; a++) begin
      sw_addr = 5'(a); sw_data = 8'(prog[a]); sw_write = 1;
      tick();
    end
    sw_write = 0; loaded = 1;
    sw_addr = 5'd21; tick();
    chk("R10 readback", disp_data, 8'hFF);
    start = 1; tick(); tick();
    chk("R10 start ignored in manual", running, 0);
    start = 0; man_mode = 0; sw_addr = 0;
    tick();
    start = 1; tick(); start = 0;
    runcyc = 0;
    while (running && runcyc < 400) begin runcyc++; tick(); end
    chk("R7 skip path cycle count", runcyc, 56);
    chk("R6 pc after jump and halt", pc, 20);
    chk("R5 acc after program", acc, 8'hFF);
    chk("R9 phase back to I1", phase, 0);
    man_mode = 1; sw_addr = 5'd22; tick();
    chk("R8 stored word", disp_data, 8'hFF);
    man_mode = 0; tick();
    start = 1; tick(); start = 0;
    runcyc = 0;
    while (running && runcyc < 400) begin runcyc++; tick(); end
    chk("R9 resumed acc", acc, 0);
    chk("R9 resumed pc", pc, 24);
    chk("R5 unused opcodes as NOP cycles", runcyc, 16);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule